// File: doc/BRIEF.md
# Precise Trap Condition Checker

This block examines one decoded instruction in its execute stage, together with the processor status bits, the register-window state and a few side inputs. From these it works out every precise trap condition that applies to that instruction. Each cause appears on its own flag, so the trap logic or a debug monitor can see all of them at once. A priority encoder also picks the single most urgent cause and reports its 8-bit trap type.

Software traps raised by a trap instruction whose condition holds are given a trap type in the upper half of the 256-entry range. The type is formed from the instruction's 7-bit trap number. Hardware causes use fixed codes below 128.

The evaluation itself is combinational. One register stage at the output, reset to zero, holds the result. A result is therefore valid one clock after the inputs are presented.

Top module: `precise_trap_checker`

## Requirements
- R1: Outputs are registered and appear one clock after the inputs. After reset, and whenever `in_valid` was low, every flag, `trap_any` and `trap_type` are zero.
- R2: Flag bit 0 (illegal) is set for each of these cases: class UNIMP (18); an unimplemented operation of any class other than FPOP (5) or CPOP (8); a status write (class 14) whose new window pointer is at or above `nwin`; an alternate-space load or store (classes 3, 4) with `imm_bit`=1; a return-from-trap (class 13) with `st_et`=1.
- R3: Flag bit 1 (privileged) is set when `op_priv`=1 and `st_s`=0.
- R4: Flag bit 2 (fp disabled) is set for classes FPOP (5), FBR (6) and FLDST (7) when `st_ef`=0 or `fpu_present`=0.
- R5: Flag bit 3 (cp disabled) is set for classes CPOP (8), CBR (9) and CLDST (10) when `st_ec`=0 or `cp_absent`=1.
- R6: For SAVE (class 11), flag bit 4 (window overflow) is `wim[(cwp-1) mod nwin]`. For RESTORE (class 12), flag bit 5 (window underflow) is `wim[(cwp+1) mod nwin]`.
- R7: Flag bit 6 (misaligned) is set in two cases. The first is a memory class (1, 2, 3, 4, 7, 10) whose address has nonzero low bits for its size (`acc_size` 0 byte, 1 half: bit 0, 2 word: bits 1:0, 3 double: bits 2:0). The second is JMPL (class 15) with `eff_addr[1:0]` nonzero.
- R8: Flag bit 9 (tag overflow) is set for class TAGTV (16) when `tag_ovf`=1.
- R9: For class TICC (17) with `ticc_taken`=1, flag bit 10 is set. When that cause is selected, `trap_type` = 128 + `sw_trap_num`, in the range 128 to 255.
- R10: An unimplemented FPOP sets flag bit 7 (fp exception) and an unimplemented CPOP sets flag bit 8 (cp exception). Neither of them sets bit 0.
- R11: `trap_type` reports the lowest-numbered set flag. The codes are: bit 0 0x02, bit 1 0x03, bit 2 0x04, bit 3 0x24, bit 4 0x05, bit 5 0x06, bit 6 0x07, bit 7 0x08, bit 8 0x28, bit 9 0x0A, bit 10 per R9. The type is 0 and `trap_any`=0 when no flag is set.
- R12: All causes that hold at the same time are shown together on `cause_flags`, whichever one is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present in execute |
| op_class | input | 5 | Instruction class code (see requirements) |
| op_unimpl | input | 1 | Decoder found the operation unimplemented |
| op_priv | input | 1 | Instruction is privileged |
| imm_bit | input | 1 | Immediate-operand bit of the instruction |
| wr_cwp | input | 3 | Window pointer a status write would install |
| st_s | input | 1 | Supervisor bit |
| st_ef | input | 1 | FP enable bit |
| st_ec | input | 1 | Coprocessor enable bit |
| st_et | input | 1 | Trap enable bit |
| cwp | input | 3 | Current window pointer |
| wim | input | 8 | Window invalid mask |
| nwin | input | 4 | Number of implemented windows (2 to 8) |
| fpu_present | input | 1 | FPU attached |
| cp_absent | input | 1 | Coprocessor missing |
| eff_addr | input | 32 | Effective address or jump target |
| acc_size | input | 2 | Access size code |
| tag_ovf | input | 1 | Overflow flag after tagged add/subtract |
| ticc_taken | input | 1 | Trap-instruction condition is true |
| sw_trap_num | input | 7 | Software trap number |
| cause_flags | output | 11 | One flag per cause |
| trap_any | output | 1 | At least one cause present |
| trap_type | output | 8 | Trap type of the selected cause |

## Verification
Some properties are checked by assertions on every cycle. These are: quiet outputs after an idle cycle; software trap types appearing only alone with their own flag; `trap_any` agreeing with the flag vector; an absent coprocessor always raising cp disabled; a fully masked window set always overflowing on SAVE; and an unimplemented FP operation never raising illegal. Other behaviour can only be shown by the bench's directed and random scenarios. This covers the wrap-around of the window pointer at the implemented count, the alignment rule for each size, the exact priority codes when causes overlap, and the status-write limit against `nwin`.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [4:0] {
        CL_OTHER     = 5'd0,
        CL_LOAD      = 5'd1,
        CL_STORE     = 5'd2,
        CL_LOAD_ALT  = 5'd3,
        CL_STORE_ALT = 5'd4,
        CL_FPOP      = 5'd5,
        CL_FBR       = 5'd6,
        CL_FLDST     = 5'd7,
        CL_CPOP      = 5'd8,
        CL_CBR       = 5'd9,
        CL_CLDST     = 5'd10,
        CL_SAVE      = 5'd11,
        CL_RESTORE   = 5'd12,
        CL_RETT      = 5'd13,
        CL_WRSTAT    = 5'd14,
        CL_JMPL      = 5'd15,
        CL_TAGTV     = 5'd16,
        CL_TICC      = 5'd17,
        CL_UNIMP     = 5'd18
    } op_class_e;

    localparam int NCAUSE    = 11;
    localparam int C_ILLEGAL = 0;
    localparam int C_PRIV    = 1;
    localparam int C_FPDIS   = 2;
    localparam int C_CPDIS   = 3;
    localparam int C_WOVF    = 4;
    localparam int C_WUNF    = 5;
    localparam int C_ALIGN   = 6;
    localparam int C_FPEXC   = 7;
    localparam int C_CPEXC   = 8;
    localparam int C_TAG     = 9;
    localparam int C_SWTRAP  = 10;

    typedef struct packed {
        logic [NCAUSE-1:0] flags;
        logic              any;
        logic [7:0]        tt;
    } trap_out_t;

    function automatic logic [7:0] hw_code(input int idx);
        case (idx)
            C_ILLEGAL: hw_code = 8'h02;
            C_PRIV:    hw_code = 8'h03;
            C_FPDIS:   hw_code = 8'h04;
            C_CPDIS:   hw_code = 8'h24;
            C_WOVF:    hw_code = 8'h05;
            C_WUNF:    hw_code = 8'h06;
            C_ALIGN:   hw_code = 8'h07;
            C_FPEXC:   hw_code = 8'h08;
            C_CPEXC:   hw_code = 8'h28;
            C_TAG:     hw_code = 8'h0A;
            default:   hw_code = 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/ptc_window_check.sv
module ptc_window_check #(
    parameter int MAX_WIN = 8,
    localparam int CWP_W  = $clog2(MAX_WIN),
    localparam int CNT_W  = CWP_W + 1
) (
    input  logic             is_save,
    input  logic             is_restore,
    input  logic             is_wrstat,
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] wr_cwp,
    input  logic [CNT_W-1:0] nwin,
    input  logic [MAX_WIN-1:0] wim,
    output logic             ovf,
    output logic             unf,
    output logic             wr_bad
);
    logic [CWP_W-1:0] prev_w;
    logic [CWP_W-1:0] next_w;
    logic [CNT_W-1:0] next_full;
    logic [CNT_W-1:0] top_w;

    always_comb begin
        top_w     = nwin - CNT_W'(1);
        next_full = {1'b0, cwp} + CNT_W'(1);
        prev_w    = (cwp == '0) ? top_w[CWP_W-1:0] : cwp - CWP_W'(1);
        next_w    = (next_full >= nwin) ? '0 : next_full[CWP_W-1:0];
        ovf       = is_save    & wim[prev_w];
        unf       = is_restore & wim[next_w];
        wr_bad    = is_wrstat  & ({1'b0, wr_cwp} >= nwin);
    end
endmodule

// File: rtl/ptc_align_check.sv
module ptc_align_check #(
    parameter int ADDR_W = 32
) (
    input  logic              is_mem,
    input  logic              is_jmpl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              misaligned
);
    logic [2:0] low_mask;

    always_comb begin
        case (size)
            2'd0:    low_mask = 3'b000;
            2'd1:    low_mask = 3'b001;
            2'd2:    low_mask = 3'b011;
            default: low_mask = 3'b111;
        endcase
        misaligned = (is_mem  & ((addr[2:0] & low_mask) != 3'b000))
                   | (is_jmpl & (addr[1:0] != 2'b00));
    end
endmodule

// File: rtl/ptc_prio_enc.sv
module ptc_prio_enc #(
    parameter int N = 11
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] sel,
    output logic         any
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign sel[i]       = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any = blocked[N];
endmodule

// File: rtl/precise_trap_checker.sv
module precise_trap_checker
    import ptc_pkg::*;
#(
    parameter int MAX_WIN  = 8,
    parameter int ADDR_W   = 32,
    localparam int CWP_W   = $clog2(MAX_WIN),
    localparam int CNT_W   = CWP_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [4:0]         op_class,
    input  logic               op_unimpl,
    input  logic               op_priv,
    input  logic               imm_bit,
    input  logic [CWP_W-1:0]   wr_cwp,
    input  logic               st_s,
    input  logic               st_ef,
    input  logic               st_ec,
    input  logic               st_et,
    input  logic [CWP_W-1:0]   cwp,
    input  logic [MAX_WIN-1:0] wim,
    input  logic [CNT_W-1:0]   nwin,
    input  logic               fpu_present,
    input  logic               cp_absent,
    input  logic [ADDR_W-1:0]  eff_addr,
    input  logic [1:0]         acc_size,
    input  logic               tag_ovf,
    input  logic               ticc_taken,
    input  logic [6:0]         sw_trap_num,
    output logic [NCAUSE-1:0]  cause_flags,
    output logic               trap_any,
    output logic [7:0]         trap_type
);
    op_class_e cls;
    logic is_fp, is_cp, is_mem, is_alt;
    logic w_ovf, w_unf, w_bad, mis;
    logic [NCAUSE-1:0] req, sel;
    logic sel_any;
    trap_out_t out_d, out_q;

    always_comb begin
        cls    = op_class_e'(op_class);
        is_fp  = in_valid & (cls inside {CL_FPOP, CL_FBR, CL_FLDST});
        is_cp  = in_valid & (cls inside {CL_CPOP, CL_CBR, CL_CLDST});
        is_alt = in_valid & (cls inside {CL_LOAD_ALT, CL_STORE_ALT});
        is_mem = in_valid & (cls inside {CL_LOAD, CL_STORE, CL_LOAD_ALT,
                                         CL_STORE_ALT, CL_FLDST, CL_CLDST});
    end

    ptc_window_check #(.MAX_WIN(MAX_WIN)) u_win (
        .is_save    (in_valid & (cls == CL_SAVE)),
        .is_restore (in_valid & (cls == CL_RESTORE)),
        .is_wrstat  (in_valid & (cls == CL_WRSTAT)),
        .cwp        (cwp),
        .wr_cwp     (wr_cwp),
        .nwin       (nwin),
        .wim        (wim),
        .ovf        (w_ovf),
        .unf        (w_unf),
        .wr_bad     (w_bad)
    );

    ptc_align_check #(.ADDR_W(ADDR_W)) u_align (
        .is_mem     (is_mem),
        .is_jmpl    (in_valid & (cls == CL_JMPL)),
        .addr       (eff_addr),
        .size       (acc_size),
        .misaligned (mis)
    );

    always_comb begin
        req            = '0;
        req[C_ILLEGAL] = in_valid & ((cls == CL_UNIMP)
                       | (op_unimpl & (cls != CL_FPOP) & (cls != CL_CPOP))
                       | w_bad
                       | (is_alt & imm_bit)
                       | ((cls == CL_RETT) & st_et));
        req[C_PRIV]    = in_valid & op_priv & ~st_s;
        req[C_FPDIS]   = is_fp & (~st_ef | ~fpu_present);
        req[C_CPDIS]   = is_cp & (~st_ec | cp_absent);
        req[C_WOVF]    = w_ovf;
        req[C_WUNF]    = w_unf;
        req[C_ALIGN]   = mis;
        req[C_FPEXC]   = in_valid & (cls == CL_FPOP) & op_unimpl;
        req[C_CPEXC]   = in_valid & (cls == CL_CPOP) & op_unimpl;
        req[C_TAG]     = in_valid & (cls == CL_TAGTV) & tag_ovf;
        req[C_SWTRAP]  = in_valid & (cls == CL_TICC) & ticc_taken;
    end

    ptc_prio_enc #(.N(NCAUSE)) u_prio (
        .req (req),
        .sel (sel),
        .any (sel_any)
    );

    always_comb begin
        out_d       = '0;
        out_d.flags = req;
        out_d.any   = sel_any;
        for (int i = 0; i < NCAUSE; i++) begin
            if (sel[i]) out_d.tt = out_d.tt | hw_code(i);
        end
        if (sel[C_SWTRAP]) out_d.tt = {1'b1, sw_trap_num};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cause_flags = out_q.flags;
    assign trap_any    = out_q.any;
    assign trap_type   = out_q.tt;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> (cause_flags == '0 && trap_type == 8'd0));

    // R9
    sw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_type[7] |-> (cause_flags == NCAUSE'(1 << C_SWTRAP)));

    // R11
    any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_any == (cause_flags != '0));

    // R5
    cp_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(cp_absent)
         && ($past(op_class) inside {CL_CPOP, CL_CBR, CL_CLDST})) |-> cause_flags[C_CPDIS]);

    // R6
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_class) == CL_SAVE && $past(&wim))
        |-> cause_flags[C_WOVF]);

    // R10
    fp_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_unimpl) && $past(op_class) == CL_FPOP)
        |-> (cause_flags[C_FPEXC] && !cause_flags[C_ILLEGAL]));
endmodule

// File: tb/precise_trap_checker_test.sv
module precise_trap_checker_test;
    import ptc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid, op_unimpl, op_priv, imm_bit;
    logic [4:0] op_class;
    logic [2:0] wr_cwp, cwp;
    logic st_s, st_ef, st_ec, st_et;
    logic [7:0] wim;
    logic [3:0] nwin;
    logic fpu_present, cp_absent, tag_ovf, ticc_taken;
    logic [31:0] eff_addr;
    logic [1:0] acc_size;
    logic [6:0] sw_trap_num;
    logic [10:0] cause_flags;
    logic trap_any;
    logic [7:0] trap_type;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    precise_trap_checker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .op_unimpl(op_unimpl), .op_priv(op_priv), .imm_bit(imm_bit),
        .wr_cwp(wr_cwp), .st_s(st_s), .st_ef(st_ef), .st_ec(st_ec),
        .st_et(st_et), .cwp(cwp), .wim(wim), .nwin(nwin),
        .fpu_present(fpu_present), .cp_absent(cp_absent), .eff_addr(eff_addr),
        .acc_size(acc_size), .tag_ovf(tag_ovf), .ticc_taken(ticc_taken),
        .sw_trap_num(sw_trap_num), .cause_flags(cause_flags),
        .trap_any(trap_any), .trap_type(trap_type)
    );

    function automatic logic [7:0] code_of(input int b);
        logic [7:0] t [11] = '{8'h02, 8'h03, 8'h04, 8'h24, 8'h05, 8'h06,
                               8'h07, 8'h08, 8'h28, 8'h0A, 8'h80};
        return t[b];
    endfunction

    function automatic logic [19:0] expect_out();
        logic [10:0] f = '0;
        logic [7:0] tt = 8'd0;
        int c = int'(op_class);
        int pw, nw;
        logic [2:0] msk;
        if (in_valid) begin
            pw = (int'(cwp) == 0) ? int'(nwin) - 1 : int'(cwp) - 1;
            nw = (int'(cwp) + 1 >= int'(nwin)) ? 0 : int'(cwp) + 1;
            msk = (acc_size == 0) ? 3'b000 : (acc_size == 1) ? 3'b001 :
                  (acc_size == 2) ? 3'b011 : 3'b111;
            f[0] = (c == 18) || (op_unimpl && c != 5 && c != 8)
                || (c == 14 && int'(wr_cwp) >= int'(nwin))
                || ((c == 3 || c == 4) && imm_bit) || (c == 13 && st_et);
            f[1] = op_priv && !st_s;
            f[2] = (c >= 5 && c <= 7) && (!st_ef || !fpu_present);
            f[3] = (c >= 8 && c <= 10) && (!st_ec || cp_absent);
            f[4] = (c == 11) && wim[pw];
            f[5] = (c == 12) && wim[nw];
            f[6] = ((c >= 1 && c <= 4) || c == 7 || c == 10) && ((eff_addr[2:0] & msk) != 0)
                || (c == 15 && eff_addr[1:0] != 0);
            f[7] = (c == 5) && op_unimpl;
            f[8] = (c == 8) && op_unimpl;
            f[9] = (c == 16) && tag_ovf;
            f[10] = (c == 17) && ticc_taken;
            for (int b = 10; b >= 0; b--)
                if (f[b]) tt = (b == 10) ? {1'b1, sw_trap_num} : code_of(b);
        end
        return {f, (f != 0), tt};
    endfunction

    task automatic step(input string req);
        logic [19:0] exp_v;
        exp_v = expect_out();
        @(negedge clk);
        n_checks++;
        if ({cause_flags, trap_any, trap_type} !== exp_v) begin
            n_errors++;
            $display("FAIL %s: got flags=%b any=%b tt=%h exp flags=%b any=%b tt=%h",
                     req, cause_flags, trap_any, trap_type,
                     exp_v[19:9], exp_v[8], exp_v[7:0]);
        end
    endtask

    task automatic defaults();
        in_valid = 1'b1; op_class = CL_OTHER; op_unimpl = 0; op_priv = 0; imm_bit = 0;
        wr_cwp = 0; st_s = 1; st_ef = 1; st_ec = 1; st_et = 0; cwp = 3'd3;
        wim = 8'h00; nwin = 4'd8; fpu_present = 1; cp_absent = 0;
        eff_addr = 32'h1000; acc_size = 2'd2; tag_ovf = 0; ticc_taken = 0;
        sw_trap_num = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4077));
        defaults();
        in_valid = 1'b0;
        op_class = CL_UNIMP;
        repeat (3) @(negedge clk);
        n_checks++;
        if (cause_flags !== '0 || trap_type !== 8'd0) begin
            n_errors++;
            $display("FAIL R1 reset: got flags=%b tt=%h exp 0", cause_flags, trap_type);
        end
        rst_n = 1'b1;
        step("R1 idle");

        defaults(); op_class = CL_UNIMP;                         step("R2 unimp");
        defaults(); op_unimpl = 1;                               step("R2 unimpl other");
        defaults(); op_class = CL_WRSTAT; nwin = 5; wr_cwp = 5;  step("R2 wrstat limit");
        defaults(); op_class = CL_WRSTAT; nwin = 5; wr_cwp = 4;  step("R2 wrstat ok");
        defaults(); op_class = CL_LOAD_ALT; imm_bit = 1;         step("R2 alt imm");
        defaults(); op_class = CL_RETT; st_et = 1;               step("R2 rett et");
        defaults(); op_priv = 1; st_s = 0;                       step("R3 user");
        defaults(); op_priv = 1; st_s = 1;                       step("R3 super");
        defaults(); op_class = CL_FPOP; st_ef = 0;               step("R4 ef off");
        defaults(); op_class = CL_FBR; fpu_present = 0;          step("R4 no fpu");
        defaults(); op_class = CL_CLDST; cp_absent = 1;          step("R5 cp absent");
        defaults(); op_class = CL_CBR; st_ec = 0;                step("R5 ec off");
        defaults(); op_class = CL_SAVE; nwin = 5; cwp = 0; wim = 8'h10; step("R6 save wrap");
        defaults(); op_class = CL_SAVE; nwin = 5; cwp = 0; wim = 8'h04; step("R6 save clear");
        defaults(); op_class = CL_RESTORE; nwin = 5; cwp = 4; wim = 8'h01; step("R6 restore wrap");
        defaults(); op_class = CL_LOAD; acc_size = 3; eff_addr = 32'h4; step("R7 double");
        defaults(); op_class = CL_STORE; acc_size = 1; eff_addr = 32'h2; step("R7 half ok");
        defaults(); op_class = CL_JMPL; eff_addr = 32'h102;      step("R7 jmpl");
        defaults(); op_class = CL_TAGTV; tag_ovf = 1;            step("R8 tag");
        defaults(); op_class = CL_TICC; ticc_taken = 1; sw_trap_num = 7'h7F; step("R9 top");
        defaults(); op_class = CL_TICC; ticc_taken = 1; sw_trap_num = 7'h00; step("R9 base");
        defaults(); op_class = CL_TICC; ticc_taken = 0; sw_trap_num = 7'h11; step("R9 not taken");
        defaults(); op_class = CL_FPOP; op_unimpl = 1;           step("R10 fp unimpl");
        defaults(); op_class = CL_CPOP; op_unimpl = 1;           step("R10 cp unimpl");
        defaults(); op_class = CL_FPOP; st_ef = 0; op_priv = 1; st_s = 0; step("R11 R12 overlap");
        defaults(); op_class = CL_TICC; ticc_taken = 1; op_priv = 1; st_s = 0; step("R11 hw over sw");

        for (int k = 0; k < 600; k++) begin
            in_valid = ($urandom_range(0, 9) != 0);
            op_class = 5'($urandom_range(0, 18));
            op_unimpl = ($urandom_range(0, 5) == 0);
            op_priv = $urandom_range(0, 1) == 1;
            imm_bit = $urandom_range(0, 1) == 1;
            st_s = $urandom_range(0, 1) == 1;
            st_ef = $urandom_range(0, 3) != 0;
            st_ec = $urandom_range(0, 3) != 0;
            st_et = $urandom_range(0, 1) == 1;
            nwin = 4'($urandom_range(2, 8));
            cwp = 3'($urandom_range(0, int'(nwin) - 1));
            wr_cwp = 3'($urandom_range(0, 7));
            wim = 8'($urandom);
            fpu_present = $urandom_range(0, 3) != 0;
            cp_absent = $urandom_range(0, 3) == 0;
            eff_addr = $urandom;
            acc_size = 2'($urandom_range(0, 3));
            tag_ovf = $urandom_range(0, 1) == 1;
            ticc_taken = $urandom_range(0, 1) == 1;
            sw_trap_num = 7'($urandom);
            step("R12 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule